// File: doc/BRIEF.md
# Signed Integer Divider with Condition Flags

This block is the divide unit of a processor execution stage. It accepts a signed dividend and a signed divisor, both `W` bits wide in two's complement, and returns a quotient truncated toward zero together with the matching remainder. It also computes the next value of the five condition flags that the divide instruction affects. The caller supplies the current flags and a hint that tells whether both results target the same destination register. The block reports which results must be written back through one write enable per result.

Operation follows a start/busy/done handshake. A start pulse is accepted only while the unit is idle. Operands, flags and the same-destination hint are captured on the accepting edge. An ordinary division runs a restoring loop on the operand magnitudes, producing one quotient bit per cycle. One more cycle then applies the sign fix-up. Two cases are recognised at start and finish on the next cycle: a zero divisor, and the most negative value divided by minus one.

Top module: `signedDivider`

## Requirements
- R1: For a nonzero divisor, other than the most negative value divided by -1, the quotient is the exact quotient rounded toward zero. The remainder equals dividend minus quotient times divisor, so its sign follows the dividend and its magnitude is below that of the divisor.
- R2: The flag vector places zero in bit 0, sign in bit 1, overflow in bit 2, carry in bit 3 and saturation in bit 4. After an ordinary division the sign flag equals the top bit of the quotient, whatever the remainder is.
- R3: After an ordinary division the zero flag is set exactly when the quotient is zero, whatever the remainder is, and the overflow flag is cleared. A zero dividend gives quotient 0, remainder 0 and zero set.
- R4: With a zero divisor the overflow flag is set. Neither write enable is raised. Zero, sign, carry and saturation keep their input values. done follows one cycle after acceptance.
- R5: The most negative value divided by -1 gives quotient equal to the most negative value and remainder 0. It sets overflow and sign, clears zero, and raises the write enables. done follows one cycle after acceptance.
- R6: When the same-destination hint is set, only the remainder write enable is raised, for both ordinary and overflowing results.
- R7: Carry and saturation in the output flags always equal the values sampled at acceptance.
- R8: For an ordinary division done rises W+2 cycles after the accepting cycle. done lasts a single cycle, busy is low whenever done is high, and the write enables are only ever high together with done.
- R9: start is ignored while busy is high. A later change of operands, flags or hint during a run does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only while idle |
| dividend | input | W | Signed dividend |
| divisor | input | W | Signed divisor |
| flagsIn | input | 5 | Current condition flags (bit map in R2) |
| sameDest | input | 1 | Quotient and remainder share one destination register |
| busy | output | 1 | An ordinary division is in progress |
| done | output | 1 | One-cycle pulse: results, enables and flags are valid |
| quotient | output | W | Signed quotient |
| remainder | output | W | Signed remainder |
| quotWe | output | 1 | Write the quotient back |
| remWe | output | 1 | Write the remainder back |
| flagsOut | output | 5 | Next condition flags (bit map in R2) |

## Verification
A wrong partial remainder or a dropped quotient bit in the magnitude loop shows up only at done, W+2 cycles after acceptance. It appears as a quotient or remainder that breaks the truncation identity, and usually also as a wrong sign or zero flag. A wrong sign latch corrupts exactly the mixed-sign operand pairs. A control counter off by one moves done away from its fixed latency. Sweeping every operand pair of a narrow instance therefore exposes each of these within the operation that triggers it.

// File: rtl/divPkg.sv
package divPkg;

  localparam int FLAG_W = 5;

  // Packed order gives zero in bit 0 up to saturation in bit 4.
  typedef struct packed {
    logic sat;
    logic carry;
    logic ovf;
    logic sign;
    logic zero;
  } flagsT;

  typedef struct packed {
    logic load;     // capture operands and begin the magnitude loop
    logic step;     // one restoring iteration
    logic finish;   // sign fix-up and result publication
    logic special;  // single-cycle result for zero divisor or MIN / -1
  } ctrlStrobesT;

endpackage

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        divZero,
  input  logic        minOvf,
  output ctrlStrobesT strobes,
  output logic        busy,
  output logic        done
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} stateT;

  stateT         state;
  logic [CW-1:0] stepCnt;
  logic          accept;
  logic          shortCut;

  assign accept   = start && (state == ST_IDLE);
  assign shortCut = divZero || minOvf;

  always_comb begin
    strobes         = '0;
    strobes.load    = accept && !shortCut;
    strobes.special = accept && shortCut;
    strobes.step    = (state == ST_RUN);
    strobes.finish  = (state == ST_FIX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobes.finish || strobes.special;
      unique case (state)
        ST_IDLE: begin
          if (strobes.load) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          if (stepCnt == LAST_STEP) begin
            state <= ST_FIX;
          end else begin
            stepCnt <= stepCnt + CW'(1);
          end
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R8
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) && start |=> (state != ST_IDLE) && !done);

  // R8
  fix_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIX) |=> done && (state == ST_IDLE));

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobesT strobes,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  flagsT       flagsIn,
  input  logic        sameDest,
  output logic        divZero,
  output logic        minOvf,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic        quotWe,
  output logic        remWe,
  output flagsT       flagsOut
);

  localparam logic [W-1:0] MIN_VAL  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = '1;

  function automatic logic [W-1:0] magOf(input logic [W-1:0] v);
    return v[W-1] ? (~v + W'(1)) : v;
  endfunction

  function automatic logic [W-1:0] negIf(input logic neg, input logic [W-1:0] v);
    return neg ? (~v + W'(1)) : v;
  endfunction

  logic [W-1:0] dvsrMag;
  logic [W-1:0] quoAcc;
  logic [W-1:0] remAcc;
  logic         negQ;
  logic         negR;
  logic         sameHold;
  flagsT        flagsHold;
  logic [W:0]   trial;
  logic [W-1:0] qFixed;
  logic [W-1:0] rFixed;

  assign divZero = (divisor == '0);
  assign minOvf  = (dividend == MIN_VAL) && (divisor == ALL_ONES);

  // Shift the next dividend bit into the partial remainder and try the subtract.
  assign trial  = {remAcc, quoAcc[W-1]} - {1'b0, dvsrMag};
  assign qFixed = negIf(negQ, quoAcc);
  assign rFixed = negIf(negR, remAcc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvsrMag   <= '0;
      quoAcc    <= '0;
      remAcc    <= '0;
      negQ      <= 1'b0;
      negR      <= 1'b0;
      sameHold  <= 1'b0;
      flagsHold <= '0;
    end else if (strobes.load) begin
      dvsrMag   <= magOf(divisor);
      quoAcc    <= magOf(dividend);
      remAcc    <= '0;
      negQ      <= dividend[W-1] ^ divisor[W-1];
      negR      <= dividend[W-1];
      sameHold  <= sameDest;
      flagsHold <= flagsIn;
    end else if (strobes.step) begin
      if (!trial[W]) begin
        remAcc <= trial[W-1:0];
        quoAcc <= {quoAcc[W-2:0], 1'b1};
      end else begin
        remAcc <= {remAcc[W-2:0], quoAcc[W-1]};
        quoAcc <= {quoAcc[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient  <= '0;
      remainder <= '0;
      quotWe    <= 1'b0;
      remWe     <= 1'b0;
      flagsOut  <= '0;
    end else begin
      quotWe <= 1'b0;
      remWe  <= 1'b0;
      if (strobes.finish) begin
        quotient       <= qFixed;
        remainder      <= rFixed;
        quotWe         <= !sameHold;
        remWe          <= 1'b1;
        flagsOut.sat   <= flagsHold.sat;
        flagsOut.carry <= flagsHold.carry;
        flagsOut.ovf   <= 1'b0;
        flagsOut.sign  <= qFixed[W-1];
        flagsOut.zero  <= (qFixed == '0);
      end else if (strobes.special) begin
        if (divZero) begin
          flagsOut     <= flagsIn;
          flagsOut.ovf <= 1'b1;
        end else begin
          quotient       <= MIN_VAL;
          remainder      <= '0;
          quotWe         <= !sameDest;
          remWe          <= 1'b1;
          flagsOut.sat   <= flagsIn.sat;
          flagsOut.carry <= flagsIn.carry;
          flagsOut.ovf   <= 1'b1;
          flagsOut.sign  <= 1'b1;
          flagsOut.zero  <= 1'b0;
        end
      end
    end
  end

  // R4
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.special && divZero |=> !quotWe && !remWe && flagsOut.ovf
      && (flagsOut.zero == $past(flagsIn.zero)) && (flagsOut.sign == $past(flagsIn.sign)));

  // R6
  same_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish && sameHold |=> remWe && !quotWe);

  // R7
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (flagsHold.carry == $past(flagsIn.carry))
      && (flagsHold.sat == $past(flagsIn.sat)));

  // R1
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    remWe && !flagsOut.ovf |-> (magOf(remainder) < dvsrMag));

  // R5
  min_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.special && !divZero |=> remWe && (remainder == '0) && flagsOut.ovf && flagsOut.sign);

endmodule

// File: rtl/signedDivider.sv
module signedDivider
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [W-1:0]      dividend,
  input  logic [W-1:0]      divisor,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic              sameDest,
  output logic              busy,
  output logic              done,
  output logic [W-1:0]      quotient,
  output logic [W-1:0]      remainder,
  output logic              quotWe,
  output logic              remWe,
  output logic [FLAG_W-1:0] flagsOut
);

  ctrlStrobesT strobes;
  logic        divZero;
  logic        minOvf;
  flagsT       flagsInS;
  flagsT       flagsOutS;

  assign flagsInS = flagsT'(flagsIn);
  assign flagsOut = flagsOutS;

  divControl #(.W(W)) i_control (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .divZero (divZero),
    .minOvf  (minOvf),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  divDatapath #(.W(W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dividend  (dividend),
    .divisor   (divisor),
    .flagsIn   (flagsInS),
    .sameDest  (sameDest),
    .divZero   (divZero),
    .minOvf    (minOvf),
    .quotient  (quotient),
    .remainder (remainder),
    .quotWe    (quotWe),
    .remWe     (remWe),
    .flagsOut  (flagsOutS)
  );

  // R8
  we_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quotWe || remWe) |-> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !$past(start) |=> !done);

  // R3
  zero_from_quot_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !flagsOut[2] |-> (flagsOut[0] == (quotient == '0)));

  // R2
  sign_from_quot_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && remWe |-> (flagsOut[1] == quotient[W-1]));

endmodule

// File: tb/test_signedDivider.sv
module test_signedDivider;

  localparam int W = 6;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [4:0]   flagsIn = '0;
  logic         sameDest = 1'b0;
  logic         busy, done, quotWe, remWe;
  logic [W-1:0] quotient, remainder;
  logic [4:0]   flagsOut;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  signedDivider #(.W(W)) i_signedDivider (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .flagsIn(flagsIn), .sameDest(sameDest), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .quotWe(quotWe), .remWe(remWe),
    .flagsOut(flagsOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [4:0] f, input logic s);
    int sa, sb, eq, er, lat;
    logic [31:0] eqv, erv;
    logic [W-1:0] expQ, expR;
    logic [4:0] expF;
    bit isZero, isMin, isNormal;
    sa = int'($signed(a));
    sb = int'($signed(b));
    isZero   = (b == '0);
    isMin    = (a == {1'b1, {(W-1){1'b0}}}) && (b == '1);
    isNormal = !isZero && !isMin;

    @(negedge clk);
    dividend = a; divisor = b; flagsIn = f; sameDest = s; start = 1'b1;
    @(negedge clk);
    lat = 1;
    if (isNormal) begin
      // R9: a second request and changed inputs while busy
      dividend = ~a; divisor = a ^ b; flagsIn = ~f; sameDest = ~s;
      check(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
    end else begin
      start = 1'b0;
    end
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
      if (lat == 3) start = 1'b0;
    end
    start = 1'b0;

    if (isZero) begin
      check(lat == 1, "R4 latency", lat, 1);
      check(!quotWe && !remWe, "R4 no write", int'({quotWe, remWe}), 0);
      expF = {f[4:3], 1'b1, f[1:0]};
      check(flagsOut == expF, "R4/R7 flags", int'(flagsOut), int'(expF));
    end else if (isMin) begin
      check(lat == 1, "R5 latency", lat, 1);
      check(quotient == a, "R5 quotient", int'(quotient), int'(a));
      check(remainder == '0, "R5 remainder", int'(remainder), 0);
      check({quotWe, remWe} == {!s, 1'b1}, "R5/R6 enables", int'({quotWe, remWe}), int'({!s, 1'b1}));
      expF = {f[4:3], 3'b110};
      check(flagsOut == expF, "R5/R7 flags", int'(flagsOut), int'(expF));
    end else begin
      eq = sa / sb;
      er = sa % sb;
      eqv = eq; erv = er;
      expQ = eqv[W-1:0];
      expR = erv[W-1:0];
      check(lat == W + 2, "R8 latency", lat, W + 2);
      check(quotient == expQ, "R1/R9 quotient", int'(quotient), int'(expQ));
      check(remainder == expR, "R1/R9 remainder", int'(remainder), int'(expR));
      check({quotWe, remWe} == {!s, 1'b1}, "R6 enables", int'({quotWe, remWe}), int'({!s, 1'b1}));
      expF = {f[4:3], 1'b0, expQ[W-1], (expQ == '0)};
      check(flagsOut[1] == expF[1], "R2 sign", int'(flagsOut[1]), int'(expF[1]));
      check(flagsOut[2:0] == expF[2:0], "R3 zero/ovf", int'(flagsOut[2:0]), int'(expF[2:0]));
      check(flagsOut[4:3] == f[4:3], "R7 carry/sat", int'(flagsOut[4:3]), int'(f[4:3]));
    end
    check(!busy, "R8 busy low with done", int'(busy), 0);
    @(negedge clk);
    check(!done && !quotWe && !remWe, "R8 single done", int'({done, quotWe, remWe}), 0);
  endtask

  initial begin
    #200000;
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !quotWe && !remWe, "R8 reset state",
          int'({busy, done, quotWe, remWe}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R8 idle after reset", int'({busy, done}), 0);
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        runOp(W'(a), W'(b), 5'((a * 7 + b * 3) % 32), ((a + b) % 5) == 0);
      end
    end
    // R3: zero dividend gives zero results and zero flag
    runOp('0, W'(5), 5'b00110, 1'b0);
    check(quotient == '0 && remainder == '0 && flagsOut[0] && !flagsOut[2],
          "R3 zero dividend", int'(flagsOut), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule